// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and date as packed BCD. It holds seconds, minutes, hours, weekday, day of month, month and a two-digit year, and it advances them from a slow tick input. The tick is a one-cycle pulse at the rate of a 32.768 kHz oscillator, sampled in the system clock domain. A prescaler turns a fixed number of ticks into one second step. The carry then ripples through the calendar, with the correct month lengths and leap Februaries for the years 2000 to 2099.

Software reaches the block through a plain register port: a write strobe, a byte address, write data, and read data that follows the address combinationally. To set the time, software raises a hold request and waits until a stopped flag reads back as set. It then writes the seven load registers and writes zero to the hold word, which restarts counting from the loaded values. A separate bank of capture registers always returns the live count. Hours can run as 00–23, or as 01–12 with a PM flag when the twelve-hour option is built in and selected.

Top module: `bcd_rtc_top`

## Requirements
- R1: After reset, both control words read 0 and the capture bank reads seconds 0x00, minutes 0x00, hours 0x00, weekday 6, day 0x01, month 0x01 and year 0x00.
- R2: Control word 0x00 has bit 0 = count enable and bit 1 = twelve-hour select. With enable clear, ticks do not change the time. With enable set and no hold, the seconds advance once every TICKS_PER_SEC ticks.
- R3: Hold word 0x04 has bit 0 = hold request (written) and bit 1 = stopped (read only). After a 1 is written to bit 0, the stopped bit reads 0 after one tick and 1 after the second tick.
- R4: While the stopped bit is set, ticks do not change any time field.
- R5: Writing 0 to the hold word clears both hold bits in the next cycle and restarts the prescaler. The first second step then comes on the TICKS_PER_SEC-th tick after the release, and counting continues from the loaded values.
- R6: Seconds and minutes step in BCD and wrap from 0x59 to 0x00, each wrap carrying into the next field.
- R7: In 24-hour mode, hours wrap from 0x23 to 0x00. That wrap advances the day and the weekday, and the weekday (0 = Sunday) wraps from 6 to 0.
- R8: In twelve-hour mode, the hour field holds BCD 01–12 in bits 4:0 and PM in bit 5. The hour 11 turns into 12 and toggles PM. The hour 12 turns into 01. Only the turn from 11 PM to 12 AM advances the day.
- R9: The day wraps to 0x01 after 0x31, 0x30 or 0x28/0x29, as the month requires. February has 29 days in every year divisible by four.
- R10: The month wraps from 0x12 to 0x01 and advances the year, and the year wraps from 0x99 to 0x00.
- R11: A write to a load register (0x10 seconds, 0x14 minutes, 0x18 hours, 0x1C weekday, 0x20 day, 0x24 month, 0x28 year) is ignored while the counter runs, meaning enable is set and stopped is clear.
- R12: Capture registers 0x30, 0x34, 0x38, 0x3C, 0x40, 0x44 and 0x48 return the live seconds, minutes, hours, weekday, day, month and year. Reads of the load addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle pulse per oscillator period |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |

## Verification
The hardest state to reach is a full cascade, where one second step must wrap every field from seconds to year, or land on February 29 of a leap year. From reset this would take years of simulated ticks. The stimulus reaches these cases through the hold handshake instead: it freezes the counter, loads a time one or two seconds before the boundary, and releases. Random loads are biased toward 59 seconds, 59 minutes, 23 hours and the last day of the month. A bench calendar model, counting in binary, predicts each result.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

   typedef struct packed {
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] day;
      logic [2:0] wday;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } cal_t;

   // Field selects for loads, in register order
   localparam logic [2:0] FLD_SEC  = 3'd0;
   localparam logic [2:0] FLD_MIN  = 3'd1;
   localparam logic [2:0] FLD_HOUR = 3'd2;
   localparam logic [2:0] FLD_WDAY = 3'd3;
   localparam logic [2:0] FLD_DAY  = 3'd4;
   localparam logic [2:0] FLD_MON  = 3'd5;
   localparam logic [2:0] FLD_YEAR = 3'd6;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
      else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Leap test on a BCD year: divisible by four
   function automatic logic bcd_leap(input logic [7:0] y);
      if (y[4]) bcd_leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      bcd_leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] bcd_last_day(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      bcd_last_day = bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: bcd_last_day = 8'h30;
         default:                    bcd_last_day = 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic clear,
   output logic adv
);
   localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

   if (TICKS_PER_SEC < 2) begin : g_bad_tps
      $error("TICKS_PER_SEC must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign adv = tick && run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clear)      cnt <= '0;
      else if (tick && run) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   // R5: a release restarts the prescaler from zero
   assert_release_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0));

endmodule

// File: rtl/rtc_hold_sync.sv
module rtc_hold_sync #(
   parameter int STOP_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic wr_hold,
   input  logic wr_bit,
   output logic hold_req,
   output logic stopped
);
   localparam int SW = (STOP_TICKS > 2) ? $clog2(STOP_TICKS) : 1;
   localparam logic [SW-1:0] LAST = SW'(STOP_TICKS - 1);

   if (STOP_TICKS < 1) begin : g_bad_stop
      $error("STOP_TICKS must be at least 1");
   end

   logic [SW-1:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_req <= 1'b0;
         stopped  <= 1'b0;
         wait_cnt <= '0;
      end else if (wr_hold) begin
         hold_req <= wr_bit;
         if (!wr_bit) begin
            stopped  <= 1'b0;
            wait_cnt <= '0;
         end
      end else if (hold_req && !stopped && tick) begin
         if (wait_cnt == LAST) stopped  <= 1'b1;
         else                  wait_cnt <= wait_cnt + 1'b1;
      end
   end

   // R3: stopped only ever rises on a tick with a request pending
   assert_stop_on_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stopped) |-> ($past(hold_req) && $past(tick)));
   // R5: writing zero clears both bits
   assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hold && !wr_bit) |=> (!hold_req && !stopped));

endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
   import bcd_rtc_pkg::*;
#(
   parameter bit HAS_12H = 1'b1
) (
   input  logic [7:0] hour,
   input  logic       h12,
   output logic [7:0] nxt,
   output logic       carry
);
   logic [7:0] nxt24;
   logic       carry24;

   always_comb begin
      carry24 = (hour == 8'h23);
      nxt24   = carry24 ? 8'h00 : bcd_inc(hour);
   end

   if (HAS_12H) begin : g_12h
      logic [4:0] base;
      logic       pm;
      logic [7:0] inc12;
      assign base  = hour[4:0];
      assign pm    = hour[5];
      assign inc12 = bcd_inc({3'b000, base});
      always_comb begin
         if (!h12) begin
            nxt   = nxt24;
            carry = carry24;
         end else if (base == 5'h11) begin
            nxt   = {2'b00, ~pm, 5'h12};
            carry = pm;
         end else if (base == 5'h12) begin
            nxt   = {2'b00, pm, 5'h01};
            carry = 1'b0;
         end else begin
            nxt   = {2'b00, pm, inc12[4:0]};
            carry = 1'b0;
         end
      end
   end else begin : g_24h
      assign nxt   = nxt24;
      assign carry = carry24;
   end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import bcd_rtc_pkg::*;
#(
   parameter bit HAS_12H = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       adv,
   input  logic       h12,
   input  logic       ld_en,
   input  logic [2:0] ld_sel,
   input  logic [7:0] ld_data,
   output cal_t       cur
);
   cal_t       nxt;
   logic [7:0] hr_nxt;
   logic       hr_carry;

   rtc_hour_step #(.HAS_12H(HAS_12H)) u_hour (
      .hour (cur.hour),
      .h12  (h12),
      .nxt  (hr_nxt),
      .carry(hr_carry)
   );

   always_comb begin
      nxt = cur;
      nxt.sec = (cur.sec == 8'h59) ? 8'h00 : bcd_inc(cur.sec);
      if (cur.sec == 8'h59) begin
         nxt.min = (cur.min == 8'h59) ? 8'h00 : bcd_inc(cur.min);
         if (cur.min == 8'h59) begin
            nxt.hour = hr_nxt;
            if (hr_carry) begin
               nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
               if (cur.day == bcd_last_day(cur.month, cur.year)) begin
                  nxt.day = 8'h01;
                  if (cur.month == 8'h12) begin
                     nxt.month = 8'h01;
                     nxt.year  = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
                  end else begin
                     nxt.month = bcd_inc(cur.month);
                  end
               end else begin
                  nxt.day = bcd_inc(cur.day);
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '{year: 8'h00, month: 8'h01, day: 8'h01, wday: 3'd6,
                  hour: 8'h00, min: 8'h00, sec: 8'h00};
      end else if (ld_en) begin
         case (ld_sel)
            FLD_SEC:  cur.sec   <= ld_data;
            FLD_MIN:  cur.min   <= ld_data;
            FLD_HOUR: cur.hour  <= ld_data;
            FLD_WDAY: cur.wday  <= ld_data[2:0];
            FLD_DAY:  cur.day   <= ld_data;
            FLD_MON:  cur.month <= ld_data;
            FLD_YEAR: cur.year  <= ld_data;
            default:  ;
         endcase
      end else if (adv) begin
         cur <= nxt;
      end
   end

   // R6: a second step at 59 seconds lands on 00
   assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld_en && cur.sec == 8'h59) |=> (cur.sec == 8'h00));
   // R4: without a step or load the time stays put
   assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !ld_en) |=> $stable(cur));
   // R10: year wraps at the end of 99
   assert_year_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld_en && cur.year == 8'h99 && cur.month == 8'h12 && cur.day == 8'h31 &&
       hr_carry && cur.min == 8'h59 && cur.sec == 8'h59) |=> (cur.year == 8'h00));

endmodule

// File: rtl/bcd_rtc_top.sv
module bcd_rtc_top
   import bcd_rtc_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768,
   parameter int STOP_TICKS    = 2,
   parameter int ADDR_W        = 8,
   parameter bit HAS_12H       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_32k,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   localparam int IW = ADDR_W - 2;
   localparam logic [IW-1:0] IDX_CTRL = IW'(0);
   localparam logic [IW-1:0] IDX_HOLD = IW'(1);
   localparam logic [IW-1:0] IDX_LD0  = IW'(4);
   localparam logic [IW-1:0] IDX_LD6  = IW'(10);
   localparam logic [IW-1:0] IDX_CAP0 = IW'(12);

   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W must be at least 7");
   end

   logic [IW-1:0] idx;
   logic [IW-1:0] ld_off;
   logic [IW-1:0] cap_off;
   logic          enable_q, h12_q;
   logic          hold_req, stopped, run, adv;
   logic          wr_hold, ld_hit, ld_en;
   cal_t          cur;

   assign idx     = addr[ADDR_W-1:2];
   assign ld_off  = idx - IDX_LD0;
   assign cap_off = idx - IDX_CAP0;
   assign run     = enable_q && !stopped;
   assign wr_hold = wr_en && (idx == IDX_HOLD);
   assign ld_hit  = wr_en && (idx >= IDX_LD0) && (idx <= IDX_LD6);
   assign ld_en   = ld_hit && !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= 1'b0;
         h12_q    <= 1'b0;
      end else if (wr_en && idx == IDX_CTRL) begin
         enable_q <= wdata[0];
         h12_q    <= wdata[1] & HAS_12H;
      end
   end

   rtc_hold_sync #(.STOP_TICKS(STOP_TICKS)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_32k),
      .wr_hold (wr_hold),
      .wr_bit  (wdata[0]),
      .hold_req(hold_req),
      .stopped (stopped)
   );

   rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_32k),
      .run  (run),
      .clear(wr_hold && !wdata[0]),
      .adv  (adv)
   );

   rtc_calendar #(.HAS_12H(HAS_12H)) u_cal (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .h12    (h12_q),
      .ld_en  (ld_en),
      .ld_sel (ld_off[2:0]),
      .ld_data(wdata),
      .cur    (cur)
   );

   always_comb begin
      rdata = 8'h00;
      if (idx == IDX_CTRL)      rdata = {6'b0, h12_q, enable_q};
      else if (idx == IDX_HOLD) rdata = {6'b0, stopped, hold_req};
      else if (idx >= IDX_CAP0 && cap_off < IW'(7)) begin
         case (cap_off[2:0])
            FLD_SEC:  rdata = cur.sec;
            FLD_MIN:  rdata = cur.min;
            FLD_HOUR: rdata = cur.hour;
            FLD_WDAY: rdata = {5'b0, cur.wday};
            FLD_DAY:  rdata = cur.day;
            FLD_MON:  rdata = cur.month;
            default:  rdata = cur.year;
         endcase
      end
   end

   // R2: a disabled counter never steps
   assert_disabled_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable_q && !ld_en) |=> $stable(cur));
   // R11: a load attempt while running leaves minutes untouched unless seconds wrap
   assert_load_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_hit && run && cur.sec != 8'h59) |=> $stable(cur.min));
   // R4: once stopped, the time is frozen until a release or a load
   assert_stopped_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !ld_en && !wr_hold) |=> $stable(cur));

endmodule

// File: tb/bcd_rtc_top_tb.sv
module bcd_rtc_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TPS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_32k = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   // model time, binary: sec, min, hour, wday, day, month, year
   int m_sec, m_min, m_hour, m_wday, m_day, m_mon, m_year;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bcd_rtc_top #(.TICKS_PER_SEC(TPS), .STOP_TICKS(2), .ADDR_W(8), .HAS_12H(1'b1)) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_32k(tick_32k),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata)
   );

   function automatic int bcd(input int v);
      return ((v / 10) * 16) + (v % 10);
   endfunction

   function automatic int dim(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic model_step();
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0; m_hour++;
            if (m_hour == 24) begin
               m_hour = 0; m_wday = (m_wday + 1) % 7; m_day++;
               if (m_day > dim(m_mon, m_year)) begin
                  m_day = 1; m_mon++;
                  if (m_mon == 13) begin
                     m_mon = 1; m_year = (m_year + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output int v);
      @(negedge clk);
      addr = a;
      #1 v = int'(rdata);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_32k = 1'b1;
         @(negedge clk); tick_32k = 1'b0;
      end
   endtask

   // raw BCD load through the handshake
   task automatic load_raw(input int s, input int mi, input int h, input int w,
                           input int d, input int mo, input int y);
      wr(8'h04, 8'h01);
      ticks(2);
      wr(8'h10, 8'(s));  wr(8'h14, 8'(mi)); wr(8'h18, 8'(h));
      wr(8'h1C, 8'(w));  wr(8'h20, 8'(d));  wr(8'h24, 8'(mo));
      wr(8'h28, 8'(y));
      wr(8'h04, 8'h00);
   endtask

   task automatic load_model();
      load_raw(bcd(m_sec), bcd(m_min), bcd(m_hour), m_wday, bcd(m_day), bcd(m_mon), bcd(m_year));
   endtask

   task automatic cmp_model(input string req);
      int v;
      rd(8'h30, v); chk(req, v, bcd(m_sec));
      rd(8'h34, v); chk(req, v, bcd(m_min));
      rd(8'h38, v); chk(req, v, bcd(m_hour));
      rd(8'h3C, v); chk(req, v, m_wday);
      rd(8'h40, v); chk(req, v, bcd(m_day));
      rd(8'h44, v); chk(req, v, bcd(m_mon));
      rd(8'h48, v); chk(req, v, bcd(m_year));
   endtask

   task automatic set_model(input int s, input int mi, input int h, input int w,
                            input int d, input int mo, input int y);
      m_sec = s; m_min = mi; m_hour = h; m_wday = w; m_day = d; m_mon = mo; m_year = y;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int v, v2;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      rd(8'h00, v); chk("R1 ctrl", v, 0);
      rd(8'h04, v); chk("R1 hold", v, 0);
      set_model(0, 0, 0, 6, 1, 1, 0);
      cmp_model("R1/R12 reset time");
      rd(8'h10, v); chk("R12 load reads zero", v, 0);

      // R2: disabled counter ignores ticks
      ticks(3 * TPS);
      rd(8'h30, v); chk("R2 disabled", v, 0);
      wr(8'h00, 8'h01);
      rd(8'h00, v); chk("R2 ctrl readback", v, 1);
      ticks(TPS);
      rd(8'h30, v); chk("R2 one second", v, 1);

      // R3: handshake timing
      wr(8'h04, 8'h01);
      rd(8'h04, v); chk("R3 request only", v, 1);
      ticks(1);
      rd(8'h04, v); chk("R3 after one tick", v, 1);
      ticks(1);
      rd(8'h04, v); chk("R3 stopped after two", v, 3);

      // R4: frozen while stopped
      rd(8'h30, v);
      ticks(3 * TPS);
      rd(8'h30, v2); chk("R4 frozen", v2, v);

      // R5: load, release, full second afterwards
      wr(8'h10, 8'h20); wr(8'h14, 8'h10); wr(8'h18, 8'h05);
      wr(8'h1C, 8'h02); wr(8'h20, 8'h15); wr(8'h24, 8'h06); wr(8'h28, 8'h30);
      wr(8'h04, 8'h00);
      rd(8'h04, v); chk("R5 release clears", v, 0);
      ticks(TPS - 1);
      rd(8'h30, v); chk("R5 before full second", v, 8'h20);
      ticks(1);
      set_model(21, 10, 5, 2, 15, 6, 30);
      cmp_model("R5 resume from loaded");

      // R11: load while running ignored
      wr(8'h10, 8'h45);
      wr(8'h20, 8'h03);
      cmp_model("R11 running load ignored");

      // R6/R7/R10: full cascade
      set_model(59, 59, 23, 6, 31, 12, 99);
      load_model(); ticks(TPS); model_step();
      cmp_model("R6/R7/R10 full wrap");
      rd(8'h3C, v); chk("R7 weekday 6->0", v, 0);

      // R9: month lengths and leap years
      set_model(59, 59, 23, 3, 28, 2, 24);
      load_model(); ticks(TPS); model_step();
      cmp_model("R9 leap Feb 28->29");
      rd(8'h40, v); chk("R9 leap day", v, 8'h29);
      set_model(59, 59, 23, 3, 28, 2, 23);
      load_model(); ticks(TPS); model_step();
      rd(8'h44, v); chk("R9 common Feb to Mar", v, 8'h03);
      set_model(59, 59, 23, 4, 29, 2, 0);
      load_model(); ticks(TPS); model_step();
      cmp_model("R9 Feb 29 to Mar 1");
      set_model(59, 59, 23, 1, 30, 4, 50);
      load_model(); ticks(TPS); model_step();
      cmp_model("R9 30-day month");
      set_model(59, 59, 23, 1, 30, 1, 50);
      load_model(); ticks(TPS); model_step();
      rd(8'h40, v); chk("R9 Jan 30->31", v, 8'h31);

      // R8: twelve-hour mode
      wr(8'h00, 8'h03);
      load_raw(8'h59, 8'h59, 8'h11, 2, 8'h05, 8'h03, 8'h24);
      ticks(TPS);
      rd(8'h38, v); chk("R8 11AM->12PM", v, 8'h32);
      rd(8'h40, v); chk("R8 no day step", v, 8'h05);
      load_raw(8'h59, 8'h59, 8'h31, 2, 8'h05, 8'h03, 8'h24);
      ticks(TPS);
      rd(8'h38, v); chk("R8 11PM->12AM", v, 8'h12);
      rd(8'h40, v); chk("R8 day step", v, 8'h06);
      rd(8'h3C, v); chk("R8 weekday step", v, 3);
      load_raw(8'h59, 8'h59, 8'h12, 2, 8'h05, 8'h03, 8'h24);
      ticks(TPS);
      rd(8'h38, v); chk("R8 12AM->01AM", v, 8'h01);
      wr(8'h00, 8'h01);

      // Random edge-biased loads, 24-hour mode (R6, R7, R9, R10)
      for (int it = 0; it < 40; it++) begin
         int y, mo, d, n;
         y  = $urandom_range(0, 99);
         mo = $urandom_range(1, 12);
         d  = ($urandom_range(0, 1) == 1) ? dim(mo, y) : $urandom_range(1, dim(mo, y));
         set_model($urandom_range(56, 59),
                   ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59),
                   ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23),
                   $urandom_range(0, 6), d, mo, y);
         load_model();
         n = $urandom_range(1, 5);
         ticks(n * TPS);
         for (int k = 0; k < n; k++) model_step();
         cmp_model("R6/R7/R9/R10 random");
      end

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule